// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a target on a two-wire serial bus (I2C, standard 7-bit addressing) that fronts a small on-chip byte array. Stores happen at bus speed. Each received data byte goes into the array as soon as its eighth bit is complete. There is no page buffer and no busy period. The target never refuses a transaction because an earlier write is still in progress.

The block samples SCL and SDA through a synchronizer, in the domain of a faster system clock. It finds START, repeated START and STOP conditions and tracks bit positions from the SCL edges. It drives SDA through one open-drain enable: a 1 pulls the line low. The upper four bits of the 7-bit device address are a parameter. The low three bits come from strap inputs.

After the device address, a write sends two memory-address bytes, high byte first, and then any number of data bytes. Reads can start from the current pointer, or from a fresh address set by an address-only write followed by a repeated START. The pointer wraps over the whole array. A write-protect input blocks changes to the array without altering the bus protocol.

Top module: `i2cmem_target`

## Requirements
- R1: After reset, and whenever the target is idle, the SDA enable `sda_oe_o` is 0 (released).
- R2: The target ACKs a device-address byte only when its upper seven bits equal `{DEV_ID, strap_i}` (default `DEV_ID` = 4'b1010). On a mismatch it keeps SDA released for the rest of the transaction: no ACK and no write, until the next START.
- R3: The memory address arrives as two bytes, high byte first, each MSB first. Only the low `ADDR_W` bits of the 16-bit value select a location. The higher bits are ignored.
- R4: Every byte of a write transaction (device address, both address bytes, data) is ACKed. A data byte is stored at the falling SCL edge that ends its eighth bit. A new transaction may start straight after STOP and is ACKed.
- R5: In a write burst the pointer moves up by one after each data byte. It wraps from location 2^ADDR_W-1 to 0, so a burst of any length is accepted.
- R6: A random read (address-only write, repeated START, device address with R/W=1) returns the byte at the loaded address.
- R7: A read that starts without an address phase returns the byte at the pointer as left by the previous read or write.
- R8: In a read the pointer moves up by one after each byte sent and wraps at the end of the array. After the master NACKs a byte, SDA stays released.
- R9: While `wp_i` is 1, data bytes are still ACKed and the pointer still advances, but the array is not modified.
- R10: A START or STOP that arrives part-way through a byte cancels that byte, and nothing is written. After START the target is ready to match a device address again.
- R11: Bus-recovery activity (nine clocks with SDA high, or START followed at once by STOP) leaves the target idle with SDA released. The array and the pointer are unchanged.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, 1 blocks array updates |

## Verification
The hardest states to reach are the two abort paths: a START or a STOP that lands part-way through a data byte, after the target has already ACKed the device and memory addresses. The stimulus reaches them with a master model that clocks out only some bits of a byte. It then raises SDA with SCL high (STOP), or raises SCL and lowers SDA (repeated START). Reads that follow show that no partial byte was stored and that the pointer still holds the address phase's value. Wrap-around is reached by a burst that starts two locations below the top of the array. A sequential read over the same locations follows, and then a current-address read that shows where the pointer ended up.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    // Protocol phases of the target controller
    typedef enum logic [3:0] {
        ST_IDLE,   // bus free or transaction closed
        ST_DEV,    // shifting in device address + R/W
        ST_AHI,    // shifting in memory address, high byte
        ST_ALO,    // shifting in memory address, low byte
        ST_WDAT,   // shifting in write data
        ST_ACK,    // target-owned acknowledge slot
        ST_RDAT,   // shifting out read data
        ST_RACK,   // master-owned acknowledge slot after read byte
        ST_IGN     // not addressed, wait for START or STOP
    } tstate_e;

    localparam int BYTE_W   = 8;
    localparam int BIT_CW   = 4;

endpackage

// File: rtl/i2cmem_bus_sense.sv
module i2cmem_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } sense_t;

    sense_t sense_d, sense_q;

    always_comb begin
        sense_d          = sense_q;
        sense_d.scl_sh   = {sense_q.scl_sh[LAST-1:0], scl_i};
        sense_d.sda_sh   = {sense_q.sda_sh[LAST-1:0], sda_i};
        sense_d.scl_prev = sense_q.scl_sh[LAST];
        sense_d.sda_prev = sense_q.sda_sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '1;   // idle bus reads high on both wires
        end else begin
            sense_q <= sense_d;
        end
    end

    assign scl_lvl   = sense_q.scl_sh[LAST];
    assign sda_lvl   = sense_q.sda_sh[LAST];
    assign scl_rise  = scl_lvl & ~sense_q.scl_prev;
    assign scl_fall  = ~scl_lvl & sense_q.scl_prev;
    assign start_evt = scl_lvl & sense_q.scl_prev & sense_q.sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & sense_q.scl_prev & ~sense_q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    // Retentive storage: deliberately not cleared by reset
    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            word_q[waddr] <= wdata;
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W      = 6,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam logic [BIT_CW-1:0] FULL_BYTE = BIT_CW'(BYTE_W);

    typedef struct packed {
        tstate_e           st;    // current protocol phase
        tstate_e           nxt;   // phase after the acknowledge slot
        logic [BIT_CW-1:0] bits;  // SCL rising edges seen in this byte
        logic [BYTE_W-1:0] sh;    // receive / transmit shift register
        logic [BYTE_W-1:0] hi;    // latched high memory-address byte
        logic [ADDR_W-1:0] ptr;   // array address pointer
        logic              oe;    // SDA pull-down enable
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic              mem_we;
    logic [BYTE_W-1:0] rd_byte;

    i2cmem_bus_sense #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cmem_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ctl_q.ptr),
        .wdata (ctl_q.sh),
        .raddr (ctl_q.ptr),
        .rdata (rd_byte)
    );

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;
        if (start_evt) begin
            ctl_d.st   = ST_DEV;
            ctl_d.bits = '0;
            ctl_d.oe   = 1'b0;
        end else if (stop_evt) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.bits = '0;
            ctl_d.oe   = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && (ctl_q.bits < FULL_BYTE)) begin
                        ctl_d.sh   = {ctl_q.sh[BYTE_W-2:0], sda_lvl};
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end else if (scl_fall && (ctl_q.bits == FULL_BYTE)) begin
                        ctl_d.bits = '0;
                        ctl_d.oe   = 1'b1;
                        ctl_d.st   = ST_ACK;
                        unique case (ctl_q.st)
                            ST_DEV: begin
                                if (ctl_q.sh[BYTE_W-1:1] == {DEV_ID, strap_i}) begin
                                    ctl_d.nxt = ctl_q.sh[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    ctl_d.st = ST_IGN;
                                    ctl_d.oe = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                ctl_d.hi  = ctl_q.sh;
                                ctl_d.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                ctl_d.ptr = ADDR_W'({ctl_q.hi, ctl_q.sh});
                                ctl_d.nxt = ST_WDAT;
                            end
                            default: begin
                                mem_we    = ~wp_i;
                                ctl_d.ptr = ctl_q.ptr + 1'b1;
                                ctl_d.nxt = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe   = 1'b0;
                        ctl_d.st   = ctl_q.nxt;
                        ctl_d.bits = '0;
                        if (ctl_q.nxt == ST_RDAT) begin
                            ctl_d.sh  = {rd_byte[BYTE_W-2:0], 1'b0};
                            ctl_d.oe  = ~rd_byte[BYTE_W-1];
                            ctl_d.ptr = ctl_q.ptr + 1'b1;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (ctl_q.bits == FULL_BYTE) begin
                            ctl_d.oe   = 1'b0;
                            ctl_d.st   = ST_RACK;
                            ctl_d.bits = '0;
                        end else begin
                            ctl_d.oe = ~ctl_q.sh[BYTE_W-1];
                            ctl_d.sh = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            ctl_d.st = ST_IGN;      // master NACK ends the read
                        end else begin
                            ctl_d.st  = ST_ACK;     // next falling edge loads a byte
                            ctl_d.nxt = ST_RDAT;
                        end
                    end
                end
                default: begin
                    // ST_IDLE, ST_IGN: only START or STOP move on
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, nxt: ST_IDLE, bits: '0, sh: '0, hi: '0,
                       ptr: '0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !sda_oe_o);                              // R1

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IGN && !start_evt) |=> (!sda_oe_o && ctl_q.st != ST_ACK)); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ctl_q.ptr == ADDR_W'($past(ctl_q.ptr) + 1'b1)));      // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (ctl_q.st == ST_IDLE && !sda_oe_o));                 // R11

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_lvl));                          // R12

endmodule

// File: tb/i2cmem_target_bench.sv
module i2cmem_target_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         AW         = 6;
    localparam int         T          = 8;      // system clocks per SCL phase
    localparam logic [2:0] STRAP      = 3'b101;
    localparam logic [6:0] DEV        = {4'b1010, STRAP};
    localparam int         NVEC       = 6;
    localparam int         WD_LIMIT   = 150000;

    // {memory address (16 bits), data byte}
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0003, 8'hA5},
        {16'h0010, 8'h3C},
        {16'h003F, 8'hFF},
        {16'h0000, 8'h81},
        {16'h0141, 8'h5A},   // high bits beyond the array are ignored -> location 1
        {16'h0022, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    int         n_checks = 0;
    int         n_fail = 0;
    int         ack_miss = 0;
    int         phase_viol = 0;
    logic       prev_oe = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cmem_target #(.ADDR_W(AW)) u_i2cmem_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (STRAP),
        .wp_i     (wp)
    );

    // R12 monitor: enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) phase_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b0; wt(T);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b1; wt(T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(T);
            scl_m = 1'b1; wt(T);
            scl_m = 1'b0; wt(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T/2);
        ack = ~sda_line;
        wt(T/2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic send_cnt(input logic [7:0] b);
        logic ak;
        send_byte(b, ak);
        if (!ak) ack_miss++;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(T);
            scl_m = 1'b1; wt(T/2);
            b[i] = sda_line;
            wt(T/2);
            scl_m = 1'b0;
        end
        wt(2);
        sda_m = nack; wt(T);
        scl_m = 1'b1; wt(T);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    task automatic rd_body(input int n);
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
        wt(4);
        chk("R8 SDA released after master NACK", {7'd0, sda_oe}, 8'h00);
        i2c_stop();
    endtask

    task automatic wr_seq(input logic [15:0] a, input int n);
        ack_miss = 0;
        i2c_start();
        send_cnt({DEV, 1'b0});
        send_cnt(a[15:8]);
        send_cnt(a[7:0]);
        for (int k = 0; k < n; k++) send_cnt(wbuf[k]);
        i2c_stop();
    endtask

    task automatic rd_rand(input logic [15:0] a, input int n);
        ack_miss = 0;
        i2c_start();
        send_cnt({DEV, 1'b0});
        send_cnt(a[15:8]);
        send_cnt(a[7:0]);
        i2c_start();
        send_cnt({DEV, 1'b1});
        rd_body(n);
    endtask

    task automatic rd_cur(input int n);
        ack_miss = 0;
        i2c_start();
        send_cnt({DEV, 1'b1});
        rd_body(n);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wt(5);
        chk("R1 reset released", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        wt(5);
        chk("R1 idle released", {7'd0, sda_oe}, 8'h00);

        // Table walk: byte write then immediate random read (R3, R4, R6)
        for (int v = 0; v < NVEC; v++) begin
            wbuf[0] = VEC[v][7:0];
            wr_seq(VEC[v][23:8], 1);
            chk("R4 all write bytes ACKed", 8'(ack_miss), 8'd0);
            rd_rand(VEC[v][23:8], 1);
            chk("R4 no busy after STOP", 8'(ack_miss), 8'd0);
            chk("R6 R3 random read data", rbuf[0], VEC[v][7:0]);
        end

        // R2: wrong strap bits -> no ACK, nothing written
        begin
            logic ak;
            int   acks = 0;
            i2c_start();
            send_byte({4'b1010, 3'b010, 1'b0}, ak); if (ak) acks++;
            send_byte(8'h00, ak); if (ak) acks++;
            send_byte(8'h03, ak); if (ak) acks++;
            send_byte(8'h11, ak); if (ak) acks++;
            i2c_stop();
            chk("R2 mismatch never ACKed", 8'(acks), 8'd0);
            rd_rand(16'h0003, 1);
            chk("R2 mismatch wrote nothing", rbuf[0], 8'hA5);
        end

        // R5: burst across the top of the array
        for (int k = 0; k < 5; k++) wbuf[k] = 8'h10 + 8'(k);
        wr_seq(16'h003E, 5);
        chk("R5 burst ACKed", 8'(ack_miss), 8'd0);
        // R8: sequential read across the wrap
        rd_rand(16'h003E, 5);
        for (int k = 0; k < 5; k++) chk("R5 R8 wrapped burst data", rbuf[k], 8'h10 + 8'(k));
        // R7: pointer left at 0x3E+5 -> 0x03
        rd_cur(1);
        chk("R7 current address read", rbuf[0], 8'hA5);

        // R9: write protect
        wp = 1'b1;
        wbuf[0] = 8'h77; wbuf[1] = 8'h78;
        wr_seq(16'h003E, 2);
        wp = 1'b0;
        chk("R9 protected bytes ACKed", 8'(ack_miss), 8'd0);
        rd_cur(1);
        chk("R9 pointer advanced", rbuf[0], 8'h12);
        rd_rand(16'h003E, 2);
        chk("R9 array unchanged 0", rbuf[0], 8'h10);
        chk("R9 array unchanged 1", rbuf[1], 8'h11);

        // R10: STOP inside a data byte
        wbuf[0] = 8'h42; wbuf[1] = 8'h43;
        wr_seq(16'h0005, 2);
        i2c_start();
        send_cnt({DEV, 1'b0}); send_cnt(8'h00); send_cnt(8'h05);
        send_bits(8'h99, 4);
        sda_m = 1'b0; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b1; wt(T);
        rd_rand(16'h0005, 1);
        chk("R10 STOP mid-byte wrote nothing", rbuf[0], 8'h42);
        // R10: repeated START inside a data byte, then current read
        i2c_start();
        send_cnt({DEV, 1'b0}); send_cnt(8'h00); send_cnt(8'h05);
        send_bits(8'hE7, 3);
        ack_miss = 0;
        i2c_start();
        send_cnt({DEV, 1'b1});
        rd_body(1);
        chk("R10 START mid-byte re-addressed", 8'(ack_miss), 8'd0);
        chk("R10 START mid-byte no write", rbuf[0], 8'h42);

        // R11: nine dummy clocks, then START+STOP, no side effects
        begin
            int oe_seen = 0;
            for (int c = 0; c < 9; c++) begin
                scl_m = 1'b1; wt(T);
                if (sda_oe) oe_seen++;
                scl_m = 1'b0; wt(T);
                if (sda_oe) oe_seen++;
            end
            i2c_start();
            i2c_stop();
            wt(4);
            chk("R11 recovery kept SDA released", 8'(oe_seen), 8'd0);
            chk("R11 idle after recovery", {7'd0, sda_oe}, 8'h00);
            rd_cur(1);
            chk("R11 pointer unchanged", rbuf[0], 8'h43);
        end

        chk("R12 SDA moved only while SCL low", 8'(phase_viol), 8'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule